// File: doc/BRIEF.md
# Partially ECC-Protected Memory Controller

This block sits between a simple request/response bus and a synchronous, word-addressed RAM that stores a data word and a separate check-bit field at each address. Only the upper part of the address space is covered by a single-error-correcting, double-error-detecting code. One stored boundary value splits the addresses. Accesses above the boundary get check bits on writes, and on reads they get a syndrome check, single-bit correction and a double-error flag. Accesses at or below the boundary pass straight through, and the code logic stays quiet for them.

After reset the controller fetches the boundary word from a fixed RAM address. It holds the whole codeword of that word in a register and decodes it on every use, so a single upset in the register never shifts the split. Bus requests are stalled until the fetch completes. After that the controller accepts one request per cycle. The address comparison costs one pipeline stage: the memory is driven in the cycle after a request is accepted, and a read response appears one cycle after the memory access.

Top module: `pecc_mem_ctrl`

## Requirements
- R1: After reset is released, the controller reads the word at address 0 (`BOOT_ADDR`). `req_ready` is low during reset and in the first cycle after release. It goes high in the cycle after the second rising edge following release and then stays high.
- R2: A request held on the bus while `req_ready` is low writes nothing to memory. It is accepted at the first rising edge with `req_ready` high and then executes normally.
- R3: The boundary is the fetched 32-bit word taken as an unsigned number. An address strictly greater than it is protected. An address equal to or below it is unprotected.
- R4: If the fetched boundary codeword has one flipped bit, the region split matches the clean value. If it has two flipped bits, every address is treated as protected.
- R5: A write is presented on the memory port (`mem_en`, `mem_we`, address, data) in the cycle after its acceptance edge. A read's `rsp_valid` is high in the cycle after the second rising edge following acceptance, and is low in the cycle before.
- R6: A protected write raises `mem_chk_we`. Bits 5:0 of `mem_wchk` are the XOR of the Hamming positions of all set data bits, where positions run from 1 to 38, powers of two are skipped, and data bit 0 sits at position 3 going upward. Bit 6 is the even parity over the 32 data bits and bits 5:0.
- R7: An unprotected write keeps `mem_chk_we` low, so the stored check bits of that word are unchanged.
- R8: A protected read of an intact word returns the written data with `rsp_corr` and `rsp_uncorr` both low. Both flags are low whenever `rsp_valid` is low.
- R9: A protected read with one flipped bit among the 39 stored bits (data or check) returns the written data with `rsp_corr` high and `rsp_uncorr` low.
- R10: A protected read with two flipped bits raises `rsp_uncorr` and keeps `rsp_corr` low.
- R11: An unprotected read returns the stored data word unaltered with both flags low, whatever the stored check bits hold.
- R12: Requests may be issued on consecutive cycles. Read responses come back one per cycle in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts requests (boundary loaded) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read data (corrected when protected) |
| rsp_corr | output | 1 | Single-bit error was corrected |
| rsp_uncorr | output | 1 | Uncorrectable error detected |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM data-word write enable |
| mem_chk_we | output | 1 | RAM check-field write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_wchk | output | CHK_W | RAM write check bits |
| mem_rdata | input | DATA_W | RAM read data, one cycle after access |
| mem_rchk | input | CHK_W | RAM read check bits, one cycle after access |

## Verification
The assertions assume that the RAM returns the word and check field of an enabled access exactly one cycle later, and that a requester keeps a request steady until `req_ready` is high. The bench models the RAM with that one-cycle read latency. It injects bit flips only while the bus is idle, so no flip ever races an access. The response-latency property also assumes that the response path starts empty after reset, which holds because the bench drives no request during reset except the one it deliberately holds against the stall.

// File: rtl/pecc_pkg.sv
// Shared helpers for the partially protected memory controller.
// Assumes a single-error-correcting Hamming code with an added overall
// parity bit; data bits fill the non-power-of-two positions from 3 up.
package pecc_pkg;

    // Outcome of a codeword check
    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } ecc_stat_e;

    // Boot sequencer states
    typedef enum logic [1:0] {
        BS_FETCH   = 2'd0,
        BS_CAPTURE = 2'd1,
        BS_RUN     = 2'd2
    } boot_st_e;

    // Number of Hamming parity bits needed for dw data bits
    function automatic int par_bits(input int dw);
        int p;
        p = 0;
        for (int k = 1; k < 16; k++) begin
            if (p == 0 && (1 << k) >= dw + k + 1) p = k;
        end
        return p;
    endfunction

    // Codeword position (1-based) of data bit idx
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int pos = 1; pos < 1024; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (cnt == idx && res == 0) res = pos;
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/pecc_enc.sv
// Check-bit generator: Hamming parity over the data bits plus one overall
// parity bit. Inputs are forced to zero when en_i is low so the XOR trees
// do not toggle for unprotected traffic.
module pecc_enc #(
    parameter int  DATA_W = 32,
    localparam int PBITS  = pecc_pkg::par_bits(DATA_W),
    localparam int CHK_W  = PBITS + 1
) (
    input  logic              en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    // Mask of data bits whose codeword position has bit j set
    function automatic logic [DATA_W-1:0] grp_mask(input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = ((pecc_pkg::data_pos(i) >> j) & 1) == 1;
        end
        return m;
    endfunction

    logic [DATA_W-1:0] d;

    // Operand isolation
    assign d = en_i ? data_i : '0;

    for (genvar j = 0; j < PBITS; j++) begin : g_par
        localparam logic [DATA_W-1:0] MASK = grp_mask(j);
        // One parity group per check bit
        assign chk_o[j] = ^(d & MASK);
    end

    // Overall parity over data and the Hamming bits
    assign chk_o[PBITS] = ^{d, chk_o[PBITS-1:0]};

endmodule

// File: rtl/pecc_dec.sv
// Syndrome generator and corrector. It recomputes the check bits with a
// generator instance, XORs them with the stored bits, flips a located data
// bit and reports the outcome. When en_i is low it reports ST_CLEAN and its
// data output is zero; the caller picks the raw word instead.
module pecc_dec #(
    parameter int  DATA_W = 32,
    localparam int PBITS  = pecc_pkg::par_bits(DATA_W),
    localparam int CHK_W  = PBITS + 1,
    localparam int NPOS   = DATA_W + PBITS
) (
    input  logic                 en_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic [CHK_W-1:0]     chk_i,
    output logic [DATA_W-1:0]    data_o,
    output pecc_pkg::ecc_stat_e  stat_o
);
    import pecc_pkg::*;

    logic [DATA_W-1:0] d;
    logic [CHK_W-1:0]  c;
    logic [CHK_W-1:0]  recomp;
    logic [PBITS-1:0]  syn;
    logic              single;
    logic [DATA_W-1:0] flip;

    // Operand isolation
    assign d = en_i ? data_i : '0;
    assign c = en_i ? chk_i  : '0;

    pecc_enc #(.DATA_W(DATA_W)) u_recomp (
        .en_i   (en_i),
        .data_i (d),
        .chk_o  (recomp)
    );

    // Syndrome and overall parity of the received word
    assign syn    = recomp[PBITS-1:0] ^ c[PBITS-1:0];
    assign single = ^(recomp ^ c);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int POS = pecc_pkg::data_pos(i);
        // Flip the data bit whose position the syndrome names
        assign flip[i] = single & (syn == PBITS'(POS));
    end

    assign data_o = d ^ flip;

    // Classify the codeword
    always_comb begin
        if (!en_i)                               stat_o = ST_CLEAN;
        else if (!single && syn == '0)           stat_o = ST_CLEAN;
        else if (single && syn <= PBITS'(NPOS))  stat_o = ST_FIXED;
        else                                     stat_o = ST_BAD;
    end

endmodule

// File: rtl/pecc_bound.sv
// Boundary holder. After reset it reads the boot word from RAM, keeps its
// full codeword, decodes it on every cycle and compares the incoming
// address against it. An uncorrectable boundary protects every address.
// Assumes the RAM returns read data one cycle after the access.
module pecc_bound #(
    parameter int  ADDR_W = 6,
    parameter int  DATA_W = 32,
    localparam int CHK_W  = pecc_pkg::par_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fetch_o,
    output logic              ready_o,
    output logic              prot_o
);
    import pecc_pkg::*;

    boot_st_e          state;
    logic [DATA_W-1:0] bnd_d;
    logic [CHK_W-1:0]  bnd_c;
    logic [DATA_W-1:0] bnd_val;
    ecc_stat_e         bnd_st;
    logic [DATA_W-1:0] addr_ext;

    // Boot sequence: issue the fetch, capture the word, then run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BS_FETCH;
            bnd_d <= '0;
            bnd_c <= '0;
        end else begin
            case (state)
                BS_FETCH:   state <= BS_CAPTURE;
                BS_CAPTURE: begin
                    bnd_d <= rd_data;
                    bnd_c <= rd_chk;
                    state <= BS_RUN;
                end
                default:    state <= BS_RUN;
            endcase
        end
    end

    assign fetch_o = (state == BS_FETCH);
    assign ready_o = (state == BS_RUN);

    pecc_dec #(.DATA_W(DATA_W)) u_bnd_dec (
        .en_i   (1'b1),
        .data_i (bnd_d),
        .chk_i  (bnd_c),
        .data_o (bnd_val),
        .stat_o (bnd_st)
    );

    // Single comparison against the corrected boundary
    assign addr_ext = DATA_W'(addr_i);
    assign prot_o   = (bnd_st == ST_BAD) | (addr_ext > bnd_val);

endmodule

// File: rtl/pecc_mem_ctrl.sv
// Partially ECC-protected memory controller (top). Stage 1 holds the
// accepted request and its region decision; stage 2 tracks an outstanding
// read. Check bits are generated only for protected writes, and read data
// is checked only for protected reads. Assumes one-cycle RAM read latency
// and a separately write-enabled check field per word.
module pecc_mem_ctrl #(
    parameter int  ADDR_W    = 6,
    parameter int  DATA_W    = 32,
    parameter int  BOOT_ADDR = 0,
    localparam int CHK_W     = pecc_pkg::par_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_corr,
    output logic              rsp_uncorr,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_chk_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [CHK_W-1:0]  mem_wchk,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [CHK_W-1:0]  mem_rchk
);
    import pecc_pkg::*;

    localparam logic [ADDR_W-1:0] BOOT_A = ADDR_W'(BOOT_ADDR);

    logic              acc;
    logic              fetch;
    logic              ready;
    logic              prot_a;
    logic              s1_valid;
    logic              s1_we;
    logic              s1_prot;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_wdata;
    logic              s2_valid;
    logic              s2_prot;
    logic              wr_prot;
    logic              rd_prot;
    logic [DATA_W-1:0] fix_data;
    ecc_stat_e         rd_stat;

    pecc_bound #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bound (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_data (mem_rdata),
        .rd_chk  (mem_rchk),
        .addr_i  (req_addr),
        .fetch_o (fetch),
        .ready_o (ready),
        .prot_o  (prot_a)
    );

    assign req_ready = ready;
    assign acc       = req_valid & ready;

    // Stage 1: register the request with its region decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_we    <= 1'b0;
            s1_prot  <= 1'b0;
            s1_addr  <= '0;
            s1_wdata <= '0;
        end else begin
            s1_valid <= acc;
            if (acc) begin
                s1_we    <= req_we;
                s1_prot  <= prot_a;
                s1_addr  <= req_addr;
                s1_wdata <= req_wdata;
            end
        end
    end

    // Stage 2: remember an outstanding read and its region
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_prot  <= 1'b0;
        end else begin
            s2_valid <= s1_valid & ~s1_we;
            s2_prot  <= s1_prot;
        end
    end

    assign wr_prot = s1_valid & s1_we & s1_prot;

    pecc_enc #(.DATA_W(DATA_W)) u_enc (
        .en_i   (wr_prot),
        .data_i (s1_wdata),
        .chk_o  (mem_wchk)
    );

    // Memory port: boot fetch first, then the stage-1 access
    assign mem_en     = fetch | s1_valid;
    assign mem_we     = s1_valid & s1_we;
    assign mem_chk_we = wr_prot;
    assign mem_addr   = fetch ? BOOT_A : s1_addr;
    assign mem_wdata  = s1_wdata;

    assign rd_prot = s2_valid & s2_prot;

    pecc_dec #(.DATA_W(DATA_W)) u_dec (
        .en_i   (rd_prot),
        .data_i (mem_rdata),
        .chk_i  (mem_rchk),
        .data_o (fix_data),
        .stat_o (rd_stat)
    );

    // Response: corrected word when protected, raw word otherwise
    assign rsp_valid  = s2_valid;
    assign rsp_rdata  = s2_prot ? fix_data : mem_rdata;
    assign rsp_corr   = (rd_stat == ST_FIXED);
    assign rsp_uncorr = (rd_stat == ST_BAD);

endmodule

// File: rtl/pecc_mem_ctrl_chk.sv
// Property checker for pecc_mem_ctrl, bound to every instance.
// Assumes the RAM answers one cycle after mem_en.
module pecc_mem_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_we,
    input logic mem_en,
    input logic mem_we,
    input logic mem_chk_we,
    input logic rsp_valid,
    input logic rsp_corr,
    input logic rsp_uncorr,
    input logic s2_prot
);

    // R2
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !(mem_en && mem_we));

    // R5
    issue_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_en && (mem_we == $past(req_we))));

    // R5
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_we, 2));

    // R7
    chk_store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_chk_we |-> (mem_en && mem_we));

    // R11
    unprot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !s2_prot) |-> !(rsp_corr || rsp_uncorr));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_corr || rsp_uncorr));

    // R10
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_corr && rsp_uncorr));

endmodule

bind pecc_mem_ctrl pecc_mem_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_chk_we (mem_chk_we),
    .rsp_valid  (rsp_valid),
    .rsp_corr   (rsp_corr),
    .rsp_uncorr (rsp_uncorr),
    .s2_prot    (s2_prot)
);

// File: tb/sim_pecc_mem_ctrl.sv
// Self-checking bench: RAM model with one-cycle read latency, bit-flip
// injection through the model, sweeps over every address and every bit.
module sim_pecc_mem_ctrl;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int CW = 7;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_corr;
    logic          rsp_uncorr;
    logic          mem_en;
    logic          mem_we;
    logic          mem_chk_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [CW-1:0] mem_wchk;
    logic [DW-1:0] mem_rdata;
    logic [CW-1:0] mem_rchk;

    logic          poke_en = 1'b0;
    logic          poke_xor = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [DW-1:0] poke_d = '0;
    logic [CW-1:0] poke_c = '0;

    logic [DW-1:0] ram_d [NW];
    logic [CW-1:0] ram_c [NW];

    int n_chk = 0;
    int n_fail = 0;
    int bnd_exp = 20;

    always #5 clk = ~clk;

    pecc_mem_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_chk_we(mem_chk_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
        .mem_rdata(mem_rdata), .mem_rchk(mem_rchk)
    );

    // RAM model with fault-injection port
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we)     ram_d[mem_addr] <= mem_wdata;
            if (mem_chk_we) ram_c[mem_addr] <= mem_wchk;
            mem_rdata <= ram_d[mem_addr];
            mem_rchk  <= ram_c[mem_addr];
        end
        if (poke_en) begin
            if (poke_xor) begin
                ram_d[poke_addr] <= ram_d[poke_addr] ^ poke_d;
                ram_c[poke_addr] <= ram_c[poke_addr] ^ poke_c;
            end else begin
                ram_d[poke_addr] <= poke_d;
                ram_c[poke_addr] <= poke_c;
            end
        end
    end

    function automatic logic [CW-1:0] enc_ref(input logic [DW-1:0] d);
        logic [5:0] s;
        int k;
        s = '0;
        k = 0;
        for (int pos = 1; pos <= 38; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (d[k]) s = s ^ 6'(pos);
                k++;
            end
        end
        return {(^d) ^ (^s), s};
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return 32'(a + 7) * 32'h9E3779B9;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input bit x,
                        input logic [DW-1:0] d, input logic [CW-1:0] c);
        poke_en = 1'b1; poke_xor = x; poke_addr = AW'(a); poke_d = d; poke_c = c;
        @(posedge clk); @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(mem_en && mem_we && mem_addr == AW'(a) && mem_wdata == d,
              "R5 write on memory port", {mem_en, mem_we, mem_addr}, {2'b11, AW'(a)});
        check(mem_chk_we == (a > bnd_exp), "R3 R7 check-field enable",
              mem_chk_we, (a > bnd_exp));
        if (a > bnd_exp)
            check(mem_wchk == enc_ref(d), "R6 check bits", mem_wchk, enc_ref(d));
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] d,
                           output logic c, output logic u);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
        while (!req_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(!rsp_valid && mem_en && !mem_we, "R5 read issued, no response yet",
              {rsp_valid, mem_en, mem_we}, 3'b010);
        @(posedge clk); @(negedge clk);
        check(rsp_valid, "R5 read response latency", rsp_valid, 1);
        d = rsp_rdata; c = rsp_corr; u = rsp_uncorr;
    endtask

    task automatic boot(input logic [DW-1:0] bw, input logic [CW-1:0] bc);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        poke(0, 1'b0, bw, bc);
        @(negedge clk);
        check(!req_ready && !rsp_valid, "R1 idle in reset", {req_ready, rsp_valid}, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!req_ready, "R1 ready low after first edge", req_ready, 0);
        @(posedge clk); @(negedge clk);
        check(req_ready, "R1 ready high after second edge", req_ready, 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        logic c;
        logic u;

        // R1 R2: boot with a request held during the stall
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        poke(0, 1'b0, 32'd20, enc_ref(32'd20));
        check(!req_ready && !rsp_valid, "R1 idle in reset", {req_ready, rsp_valid}, 0);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(40); req_wdata = 32'hCAFEF00D;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(!req_ready, "R1 ready low after first edge", req_ready, 0);
        check(!(mem_en && mem_we), "R2 no write while stalled", mem_we, 0);
        @(posedge clk); @(negedge clk);
        check(req_ready, "R1 ready high after second edge", req_ready, 1);
        check(!(mem_en && mem_we), "R2 no write before acceptance", mem_we, 0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(mem_en && mem_we && mem_addr == AW'(40) && mem_chk_we,
              "R2 held write executes", {mem_en, mem_we, mem_chk_we}, 3'b111);
        do_read(40, d, c, u);
        check(d == 32'hCAFEF00D && !c && !u, "R2 held write data", d, 32'hCAFEF00D);

        // R3 R6 R7: write every address
        for (int a = 0; a < NW; a++) do_write(a, pat(a));

        // R8 R11: read every address intact
        for (int a = 0; a < NW; a++) begin
            do_read(a, d, c, u);
            check(d == pat(a) && !c && !u, "R8 R11 clean read", {c, u, d}, {2'b00, pat(a)});
        end

        // R9: every single-bit flip of a protected word
        for (int b = 0; b < 39; b++) begin
            logic [DW-1:0] dm;
            logic [CW-1:0] cm;
            dm = (b < 32) ? (32'd1 << b) : '0;
            cm = (b >= 32) ? CW'(1 << (b - 32)) : '0;
            poke(63, 1'b1, dm, cm);
            do_read(63, d, c, u);
            check(d == pat(63) && c && !u, "R9 single flip corrected", {c, u, d}, {2'b10, pat(63)});
            poke(63, 1'b1, dm, cm);
        end
        poke(21, 1'b1, 32'h0000_8000, '0);
        do_read(21, d, c, u);
        check(d == pat(21) && c && !u, "R9 R3 first protected address", {c, u, d}, {2'b10, pat(21)});
        poke(21, 1'b1, 32'h0000_8000, '0);

        // R10: adjacent two-bit flips
        for (int b = 0; b < 38; b++) begin
            logic [38:0] m;
            m = (39'd3 << b);
            poke(50, 1'b1, m[31:0], m[38:32]);
            do_read(50, d, c, u);
            check(u && !c, "R10 double flip flagged", {c, u}, 2'b01);
            poke(50, 1'b1, m[31:0], m[38:32]);
        end

        // R11 R3: boundary address is unprotected, check field ignored
        poke(20, 1'b1, 32'h0000_0008, 7'h7F);
        do_read(20, d, c, u);
        check(d == (pat(20) ^ 32'h8) && !c && !u, "R11 R3 raw data at boundary",
              {c, u, d}, {2'b00, pat(20) ^ 32'h8});
        poke(20, 1'b1, 32'h0000_0008, 7'h7F);

        // R12: back-to-back reads across the boundary
        for (int k = 0; k < 12; k++) begin
            if (k >= 2)
                check(rsp_valid && rsp_rdata == pat(14 + k) && !rsp_corr && !rsp_uncorr,
                      "R12 in-order pipelined read", rsp_rdata, pat(14 + k));
            if (k < 10) begin
                req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(16 + k);
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk); @(negedge clk);
        end

        // R4: boundary codeword with bit 2 flipped (would read as 16)
        poke(18, 1'b1, '0, 7'h55);
        boot(32'd16, enc_ref(32'd20));
        bnd_exp = 20;
        do_read(18, d, c, u);
        check(d == pat(18) && !c && !u, "R4 corrected boundary keeps 18 unprotected",
              {c, u, d}, {2'b00, pat(18)});
        do_write(17, pat(17));
        poke(21, 1'b1, 32'h0000_0020, '0);
        do_read(21, d, c, u);
        check(d == pat(21) && c && !u, "R4 corrected boundary keeps 21 protected",
              {c, u, d}, {2'b10, pat(21)});

        // R4: uncorrectable boundary protects everything
        boot(32'd20 ^ 32'h3, enc_ref(32'd20));
        bnd_exp = -1;
        do_write(1, pat(1));
        do_read(1, d, c, u);
        check(d == pat(1) && !c && !u, "R4 fail-safe protected read", {c, u, d}, {2'b00, pat(1)});

        finish_run();
    end

endmodule